// File: doc/BRIEF.md
# Folded 9/7 Lifting Wavelet Line Transform

This block computes a one-level forward 9/7 wavelet transform of one image line at a time. Samples arrive as signed fixed-point words, one per clock while a valid flag is high, and the first sample of each line carries a line-start flag. When a full line of `LINE_LEN` samples has been captured, a single shared lifting unit walks the line four times. It updates the odd (detail) positions on the two predict passes and the even (smooth) positions on the two update passes, with a different coefficient on each pass. The block then streams out normalised low-pass/high-pass pairs, one pair per clock.

The controller is a four-state machine. IDLE waits for a line start. IDLE->LOAD fires on a valid sample with the line-start flag. LOAD stores samples in order. LOAD->LOAD restarts the capture when another line-start arrives, and LOAD->LIFT fires when the last sample of the line is stored. LIFT runs `LINE_LEN/2` cycles per pass for four passes, and LIFT->EMIT fires after the final element of the fourth pass. EMIT drives one output pair per cycle, and EMIT->IDLE fires after the last pair. Inputs are not accepted in LIFT and EMIT.

Top module: `dwt97_fold_core`

## Requirements
- R1: While reset is held and right after it is released, `out_valid_o` and `out_first_o` are 0.
- R2: A line starts with a sample that has both `in_valid_i` and `in_sol_i` set. The next `LINE_LEN-1` samples with `in_valid_i` set fill the line in order. Cycles with `in_valid_i` low are skipped without effect.
- R3: Samples presented during LIFT or EMIT, including line-start samples, are dropped. They change neither the line in progress nor any later output.
- R4: A line-start sample arriving during LOAD discards the partial line and becomes sample 0 of a new line.
- R5: Each lifting operation adds round(c*(a+b)) to its target, where round(p) = (p + 8192) >> 14 (arithmetic shift). The coefficients are Q2.14 integers, used in pass order: pass 0 -25987, pass 1 -868, pass 2 14466, pass 3 7266.
- R6: Predict passes (0 and 2) update odd sample 2i+1 from even neighbours 2i and 2i+2. At the right edge, position LINE_LEN (one past the end) is taken as LINE_LEN-2.
- R7: Update passes (1 and 3) update even sample 2i from odd neighbours 2i-1 and 2i+1. At the left edge, position -1 is taken as 1.
- R8: Output low-pass values are round(s*14252) and high-pass values are round(d*18835), using the rounding of R5.
- R9: Output pair i carries low-pass element i (from position 2i) and high-pass element i (from position 2i+1). Pairs come in ascending i on consecutive cycles, and `out_first_o` is set only with pair 0.
- R10: Pair 0 becomes valid exactly 2*LINE_LEN+1 clock edges after the edge that captures the last sample of a line.
- R11: Exactly LINE_LEN/2 pairs are produced per line. `out_valid_o` then stays low until another complete line has been captured and transformed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | Input sample qualifier |
| in_sol_i | input | 1 | Marks the first sample of a line |
| in_data_i | input | IW | Signed input sample |
| out_valid_o | output | 1 | Output pair qualifier |
| out_first_o | output | 1 | Marks pair 0 of a line |
| out_low_o | output | IW+GUARD | Signed normalised low-pass coefficient |
| out_high_o | output | IW+GUARD | Signed normalised high-pass coefficient |

## Verification
Several properties are checked on every cycle. A gap in LOAD leaves the capture position untouched. A busy transform is never pushed back into LOAD by incoming samples. The first-pair flag only appears on a valid pair, pairs after the first come on back-to-back cycles, and the valid flag falls only outside LIFT and EMIT. The bench scenarios are what show the arithmetic itself. They cover the rounded coefficient products on ramps, random, extreme and alternating lines, and the mirrored edges through impulses at either end of a line. They also cover the exact latency to the first pair, a restarted capture, and lines that are dropped because they arrived while the block was busy.

// File: rtl/dwt97_pkg.sv
package dwt97_pkg;

    localparam int COEF_W = 16;
    localparam int FRAC_B = 14;

    typedef logic signed [COEF_W-1:0] coef_t;

    // Q2.14 lifting and normalisation constants
    localparam coef_t C_STEP0 = -16'sd25987;
    localparam coef_t C_STEP1 = -16'sd868;
    localparam coef_t C_STEP2 = 16'sd14466;
    localparam coef_t C_STEP3 = 16'sd7266;
    localparam coef_t C_KINV  = 16'sd14252;
    localparam coef_t C_KSCL  = 16'sd18835;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_LIFT,
        ST_EMIT
    } fsm_t;

    function automatic coef_t step_coef(input logic [1:0] pass);
        coef_t c;
        unique case (pass)
            2'd0: c = C_STEP0;
            2'd1: c = C_STEP1;
            2'd2: c = C_STEP2;
            default: c = C_STEP3;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dwt97_lift_unit.sv
module dwt97_lift_unit
    import dwt97_pkg::*;
#(
    parameter int WW = 14
) (
    input  logic signed [WW-1:0] nb_a,
    input  logic signed [WW-1:0] nb_b,
    input  logic signed [WW-1:0] tgt,
    input  coef_t                coef,
    output logic signed [WW-1:0] res
);
    localparam int PW = WW + 1 + COEF_W;
    localparam logic signed [PW-1:0] RND = PW'(1) <<< (FRAC_B - 1);

    logic signed [WW:0]   pair_sum;
    logic signed [PW-1:0] prod;

    always_comb begin
        pair_sum = {nb_a[WW-1], nb_a} + {nb_b[WW-1], nb_b};
        prod     = PW'(pair_sum) * PW'(coef);
        res      = WW'(PW'(tgt) + ((prod + RND) >>> FRAC_B));
    end
endmodule

// File: rtl/dwt97_scale_unit.sv
module dwt97_scale_unit
    import dwt97_pkg::*;
#(
    parameter int WW = 14
) (
    input  logic signed [WW-1:0] lo_in,
    input  logic signed [WW-1:0] hi_in,
    output logic signed [WW-1:0] lo_out,
    output logic signed [WW-1:0] hi_out
);
    localparam int PW = WW + COEF_W;
    localparam logic signed [PW-1:0] RND = PW'(1) <<< (FRAC_B - 1);

    logic signed [PW-1:0] lo_prod;
    logic signed [PW-1:0] hi_prod;

    always_comb begin
        lo_prod = PW'(lo_in) * PW'(C_KINV);
        hi_prod = PW'(hi_in) * PW'(C_KSCL);
        lo_out  = WW'((lo_prod + RND) >>> FRAC_B);
        hi_out  = WW'((hi_prod + RND) >>> FRAC_B);
    end
endmodule

// File: rtl/dwt97_fold_core.sv
module dwt97_fold_core
    import dwt97_pkg::*;
#(
    parameter int IW       = 10,
    parameter int GUARD    = 4,
    parameter int LINE_LEN = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid_i,
    input  logic                       in_sol_i,
    input  logic signed [IW-1:0]       in_data_i,
    output logic                       out_valid_o,
    output logic                       out_first_o,
    output logic signed [IW+GUARD-1:0] out_low_o,
    output logic signed [IW+GUARD-1:0] out_high_o
);
    localparam int WW   = IW + GUARD;
    localparam int HALF = LINE_LEN / 2;
    localparam int AW   = $clog2(LINE_LEN);
    localparam int HW   = $clog2(HALF);

    fsm_t state_q, state_nxt;

    logic signed [WW-1:0] line_q [LINE_LEN];
    logic [AW-1:0]        ld_idx_q;
    logic [HW-1:0]        idx_q;
    logic [1:0]           pass_q;

    logic [AW-1:0]        a_even, a_odd, a_next, a_prev, wr_addr;
    logic                 is_pred, first_i, last_i;
    logic signed [WW-1:0] nb_a, nb_b, tgt, lift_res, sc_lo, sc_hi, in_ext;

    // operand selection with mirrored edges
    always_comb begin
        a_even  = {idx_q, 1'b0};
        a_odd   = {idx_q, 1'b1};
        a_next  = a_even + AW'(2);
        a_prev  = a_even - AW'(1);
        is_pred = ~pass_q[0];
        first_i = (idx_q == '0);
        last_i  = (idx_q == HW'(HALF - 1));
        in_ext  = WW'(in_data_i);
        if (is_pred) begin
            nb_a    = line_q[a_even];
            nb_b    = last_i ? line_q[a_even] : line_q[a_next];
            tgt     = line_q[a_odd];
            wr_addr = a_odd;
        end else begin
            nb_a    = first_i ? line_q[a_odd] : line_q[a_prev];
            nb_b    = line_q[a_odd];
            tgt     = line_q[a_even];
            wr_addr = a_even;
        end
    end

    dwt97_lift_unit #(.WW(WW)) lift_i (
        .nb_a (nb_a),
        .nb_b (nb_b),
        .tgt  (tgt),
        .coef (step_coef(pass_q)),
        .res  (lift_res)
    );

    dwt97_scale_unit #(.WW(WW)) scale_i (
        .lo_in  (line_q[a_even]),
        .hi_in  (line_q[a_odd]),
        .lo_out (sc_lo),
        .hi_out (sc_hi)
    );

    // next-state logic
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid_i && in_sol_i) state_nxt = ST_LOAD;
            ST_LOAD: if (in_valid_i && !in_sol_i && ld_idx_q == AW'(LINE_LEN - 1))
                         state_nxt = ST_LIFT;
            ST_LIFT: if (last_i && pass_q == 2'd3) state_nxt = ST_EMIT;
            ST_EMIT: if (last_i) state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_nxt;
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            ld_idx_q    <= '0;
            idx_q       <= '0;
            pass_q      <= '0;
            out_valid_o <= 1'b0;
            out_first_o <= 1'b0;
            out_low_o   <= '0;
            out_high_o  <= '0;
        end else begin
            out_valid_o <= 1'b0;
            out_first_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    idx_q  <= '0;
                    pass_q <= '0;
                    if (in_valid_i && in_sol_i) begin
                        line_q[0] <= in_ext;
                        ld_idx_q  <= AW'(1);
                    end
                end
                ST_LOAD: begin
                    if (in_valid_i) begin
                        if (in_sol_i) begin
                            line_q[0] <= in_ext;
                            ld_idx_q  <= AW'(1);
                        end else begin
                            line_q[ld_idx_q] <= in_ext;
                            ld_idx_q         <= ld_idx_q + AW'(1);
                        end
                    end
                end
                ST_LIFT: begin
                    line_q[wr_addr] <= lift_res;
                    if (last_i) begin
                        idx_q  <= '0;
                        pass_q <= pass_q + 2'd1;
                    end else begin
                        idx_q <= idx_q + HW'(1);
                    end
                end
                ST_EMIT: begin
                    out_low_o   <= sc_lo;
                    out_high_o  <= sc_hi;
                    out_valid_o <= 1'b1;
                    out_first_o <= first_i;
                    idx_q       <= last_i ? '0 : idx_q + HW'(1);
                end
            endcase
        end
    end

    // R2: an input gap during capture leaves the write position unchanged
    a_r2_gap_hold: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOAD && !in_valid_i) |=> (state_q == ST_LOAD && $stable(ld_idx_q)));

    // R3: incoming samples never pull a busy transform back into capture
    a_r3_busy_ignores: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_LIFT || state_q == ST_EMIT) && in_valid_i) |=> (state_q != ST_LOAD));

    // R9: first-pair marker only accompanies a valid pair
    a_r9_first_valid: assert property (@(posedge clk) disable iff (rst)
        out_first_o |-> out_valid_o);

    // R9: pairs after the first follow on consecutive cycles
    a_r9_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && !out_first_o) |-> $past(out_valid_o));

    // R11: output stream ends only once lifting and emission are over
    a_r11_idle_after: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid_o) |-> (state_q != ST_LIFT && state_q != ST_EMIT));

endmodule

// File: tb/dwt97_fold_core_tb_top.sv
module dwt97_fold_core_tb_top;
    localparam int IW   = 10;
    localparam int WW   = 14;
    localparam int N    = 16;
    localparam int H    = N / 2;
    localparam int WD   = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_sol = 1'b0;
    logic signed [IW-1:0] in_data = '0;
    logic out_valid, out_first;
    logic signed [WW-1:0] out_low, out_high;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int t_last = 0;
    bit done   = 1'b0;

    int    q_lo[$];
    int    q_hi[$];
    bit    q_first[$];
    string q_tag[$];

    always #5 clk = ~clk;

    dwt97_fold_core #(.IW(IW), .GUARD(WW - IW), .LINE_LEN(N)) dut_i (
        .clk(clk), .rst(rst),
        .in_valid_i(in_valid), .in_sol_i(in_sol), .in_data_i(in_data),
        .out_valid_o(out_valid), .out_first_o(out_first),
        .out_low_o(out_low), .out_high_o(out_high)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD && !done) begin
            fails++;
            $display("FAIL watchdog: run hung, actual cycle %0d expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    function automatic int rm(input int v, input int c);
        longint p;
        p = longint'(v) * longint'(c) + 64'sd8192;
        return int'(p >>> 14);
    endfunction

    // expected values per R5 R6 R7 R8 R9
    task automatic push_model(input int smp[N], input string tag);
        int x[N];
        int cf[4] = '{-25987, -868, 14466, 7266};
        for (int k = 0; k < N; k++) x[k] = smp[k];
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < H; i++) begin
                if (p % 2 == 0)
                    x[2*i+1] += rm(x[2*i] + ((i == H-1) ? x[2*i] : x[2*i+2]), cf[p]);
                else
                    x[2*i] += rm(((i == 0) ? x[1] : x[2*i-1]) + x[2*i+1], cf[p]);
            end
        end
        for (int i = 0; i < H; i++) begin
            q_lo.push_back(rm(x[2*i], 14252));
            q_hi.push_back(rm(x[2*i+1], 18835));
            q_first.push_back(i == 0);
            q_tag.push_back(tag);
        end
    endtask

    task automatic drive_line(input int smp[N], input int n, input bit expect_out,
                              input bit gaps, input string tag);
        if (expect_out) push_model(smp, tag);
        for (int k = 0; k < n; k++) begin
            if (gaps && (k % 3 == 2)) begin
                in_valid = 1'b0;
                in_data  = IW'(-7);
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_sol   = (k == 0);
            in_data  = IW'(smp[k]);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_sol   = 1'b0;
        if (expect_out) t_last = cyc;
    endtask

    task automatic wait_drain();
        while (q_lo.size() != 0) @(negedge clk);
        repeat (12) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R11: out_valid after drain actual %0b expected 0", out_valid);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q_lo.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R11 R3: unexpected pair actual lo=%0d hi=%0d expected none",
                         out_low, out_high);
            end else begin
                int elo, ehi;
                bit efi;
                string tg;
                elo = q_lo.pop_front();
                ehi = q_hi.pop_front();
                efi = q_first.pop_front();
                tg  = q_tag.pop_front();
                checks++;
                if (int'(out_low) != elo || int'(out_high) != ehi || out_first != efi) begin
                    fails++;
                    $display("FAIL %s R5 R8 R9: actual lo=%0d hi=%0d first=%0b expected lo=%0d hi=%0d first=%0b",
                             tg, out_low, out_high, out_first, elo, ehi, efi);
                end
                if (efi) begin
                    checks++;
                    if (cyc - t_last != 2*N + 1) begin
                        fails++;
                        $display("FAIL R10: latency actual %0d expected %0d", cyc - t_last, 2*N + 1);
                    end
                end
            end
        end
    end

    initial begin
        int s[N];
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_first !== 1'b0) begin
            fails++;
            $display("FAIL R1: in reset actual valid=%0b first=%0b expected 0 0", out_valid, out_first);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_first !== 1'b0) begin
            fails++;
            $display("FAIL R1: after reset actual valid=%0b first=%0b expected 0 0", out_valid, out_first);
        end

        // ramp, continuous input (R5 R9 R10)
        for (int k = 0; k < N; k++) s[k] = k * 37 - 300;
        drive_line(s, N, 1'b1, 1'b0, "R5_ramp");
        wait_drain();

        // random with gaps (R2)
        for (int k = 0; k < N; k++) s[k] = int'($urandom_range(0, 1023)) - 512;
        drive_line(s, N, 1'b1, 1'b1, "R2_gaps");
        wait_drain();

        // right-edge impulse (R6)
        for (int k = 0; k < N; k++) s[k] = 0;
        s[N-1] = 400;
        drive_line(s, N, 1'b1, 1'b0, "R6_right_edge");
        wait_drain();

        // left-edge impulse (R7)
        for (int k = 0; k < N; k++) s[k] = 0;
        s[0] = -450;
        s[1] = 300;
        drive_line(s, N, 1'b1, 1'b0, "R7_left_edge");
        wait_drain();

        // constant line, normalisation (R8)
        for (int k = 0; k < N; k++) s[k] = 100;
        drive_line(s, N, 1'b1, 1'b0, "R8_const");
        wait_drain();

        // extremes and alternation (R5)
        for (int k = 0; k < N; k++) s[k] = 511;
        drive_line(s, N, 1'b1, 1'b0, "R5_max");
        wait_drain();
        for (int k = 0; k < N; k++) s[k] = -512;
        drive_line(s, N, 1'b1, 1'b0, "R5_min");
        wait_drain();
        for (int k = 0; k < N; k++) s[k] = (k % 2 == 0) ? 511 : -512;
        drive_line(s, N, 1'b1, 1'b0, "R5_alt");
        wait_drain();

        // restart during capture (R4)
        for (int k = 0; k < N; k++) s[k] = 200 - k * 11;
        drive_line(s, 5, 1'b0, 1'b0, "R4_partial");
        for (int k = 0; k < N; k++) s[k] = int'($urandom_range(0, 1023)) - 512;
        drive_line(s, N, 1'b1, 1'b0, "R4_restart");
        wait_drain();

        // line arriving while busy is dropped (R3)
        for (int k = 0; k < N; k++) s[k] = k * k - 100;
        drive_line(s, N, 1'b1, 1'b0, "R3_kept");
        for (int k = 0; k < N; k++) s[k] = 250;
        drive_line(s, N, 1'b0, 1'b0, "R3_dropped");
        wait_drain();

        // normal line after the dropped one (R3 R11)
        for (int k = 0; k < N; k++) s[k] = int'($urandom_range(0, 1023)) - 512;
        drive_line(s, N, 1'b1, 1'b1, "R3_after");
        wait_drain();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule